// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed operands on a grid of multiply-accumulate cells that share one clock. Every cell keeps its own accumulator, so the cell at row i and column j builds output element C[i][j] in place. The block sets up its own input timing. Each row of A enters the grid from the left edge and each column of B enters from the top edge. Row i and column j each start i or j cycles late. Zeros fill the edges before and after the real data. Every cell adds a*b to its accumulator and hands both operands on, unchanged, to its right and lower neighbours one cycle later.

A one-cycle start pulse captures both operand matrices and begins a run. Compute takes 3N-2 cycles. After compute, the accumulators are joined into one shift chain and the products leave the block on a single result port, one per cycle in row-major order, each marked by a valid strobe. A one-cycle done flag follows the last result. The grid is N x N with N = 3 by default.

Top module: `osmm_array`

## Requirements
- R1: After a synchronous reset, out_valid and done are 0 and out_data is 0.
- R2: Element (i,j) of a_mat and b_mat sits in bits [(i*N+j)*8 +: 8] as an 8-bit two's-complement value. The result stream carries C[i][j] = sum over k of A[i][k]*B[k][j], exact, as a 20-bit two's-complement value.
- R3: Results appear on N*N consecutive cycles with out_valid high, in row-major order: C[0][0], C[0][1], ... C[N-1][N-1].
- R4: When start is sampled high in an idle cycle at clock edge E0, the first valid result is present in the cycle that follows edge E0+3N-1 (3N-2 compute edges plus one drain edge).
- R5: done is high for exactly one cycle, in the cycle right after the last valid result, and out_valid is low in that cycle.
- R6: A start pulse that arrives while a run is in progress is ignored. The run in progress gives unchanged results and timing, and no second run follows.
- R7: Each accepted start clears every accumulator in the same cycle as the first operand step, so no residue from an earlier run reaches the new results.
- R8: Operand matrices are captured on the accepted start edge. Changes on a_mat or b_mat during a run have no effect on that run's results.
- R9: Extreme operands (all -128, or -128 against 127) give exact results without overflow: 49152 and -48768 for N = 3.
- R10: A start given in the cycle where done is high is accepted, and a complete new run follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| a_mat | input | N*N*DW | Left operand matrix, row-major, DW bits per element |
| b_mat | input | N*N*DW | Right operand matrix, row-major, DW bits per element |
| out_data | output | AW | Product element being drained |
| out_valid | output | 1 | out_data holds a result |
| done | output | 1 | One-cycle flag after the last result |

## Verification
The identity matrix used as A shows whether the skew routes B's columns to the correct cells, because any misrouting gives a visibly permuted copy of B. Random signed matrices check the full sum of products and the drain order. Saturated -128/127 patterns check the accumulator width and sign extension. An all-zero run that follows straight after a loaded run shows residue that was never cleared. Further runs with a start pulse in mid-run, operand changes after capture, and a restart in the done cycle check R6, R8 and R10 through the result stream and its cycle-exact timing.

// File: rtl/osmm_pkg.sv
package osmm_pkg;
  localparam int DIM_DEF   = 3;
  localparam int OPW_DEF   = 8;
  localparam int ACCW_DEF  = 20;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_COMP  = 2'd1,
    SEQ_DRAIN = 2'd2,
    SEQ_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mm_sequencer.sv
module mm_sequencer #(
  parameter int N  = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          capture,
  output logic          comp_en,
  output logic          clr_acc,
  output logic          shift_en,
  output logic [CW-1:0] step,
  output logic          valid_q,
  output logic          done_q
);
  import osmm_pkg::*;

  localparam int COMP_CYC  = 3 * N - 2;
  localparam int DRAIN_CYC = N * N;

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= (state == SEQ_DRAIN);
      done_q  <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_COMP;
            cnt   <= '0;
          end
        end
        SEQ_COMP: begin
          if (cnt == CW'(COMP_CYC - 1)) begin
            state <= SEQ_DRAIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_DRAIN: begin
          if (cnt == CW'(DRAIN_CYC - 1)) begin
            state <= SEQ_FIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          done_q <= 1'b1;
          state  <= SEQ_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    busy     = (state != SEQ_IDLE);
    capture  = (state == SEQ_IDLE) && start;
    comp_en  = (state == SEQ_COMP);
    clr_acc  = comp_en && (cnt == '0);
    shift_en = (state == SEQ_DRAIN);
    step     = cnt;
  end
endmodule

// File: rtl/mm_edge_feeder.sv
module mm_edge_feeder #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            comp_en,
  input  logic [CW-1:0]   step,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic [N*DW-1:0] a_edge,
  output logic [N*DW-1:0] b_edge
);
  localparam int MW = N * N * DW;

  logic [MW-1:0] a_q;
  logic [MW-1:0] b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (capture) begin
      a_q <= a_mat;
      b_q <= b_mat;
    end
  end

  // Row r (or column r) is delayed by r steps; outside its window it feeds zero.
  for (genvar r = 0; r < N; r++) begin : g_lane
    logic [DW-1:0] a_lane;
    logic [DW-1:0] b_lane;
    int            k;

    always_comb begin
      k      = int'(step) - r;
      a_lane = '0;
      b_lane = '0;
      if (comp_en && k >= 0 && k < N) begin
        a_lane = a_q[(r * N + k) * DW +: DW];
        b_lane = b_q[(k * N + r) * DW +: DW];
      end
    end

    assign a_edge[r*DW +: DW] = a_lane;
    assign b_edge[r*DW +: DW] = b_lane;
  end
endmodule

// File: rtl/mm_mac_cell.sv
module mm_mac_cell #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 comp_en,
  input  logic                 clr_acc,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] b_in,
  input  logic signed [AW-1:0] acc_in,
  output logic signed [DW-1:0] a_out,
  output logic signed [DW-1:0] b_out,
  output logic signed [AW-1:0] acc_out
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] base;

  always_comb begin
    prod     = a_in * b_in;
    prod_ext = {{(AW - PW){prod[PW-1]}}, prod};
    base     = clr_acc ? '0 : acc_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out   <= '0;
      b_out   <= '0;
      acc_out <= '0;
    end else begin
      a_out <= a_in;
      b_out <= b_in;
      if (comp_en) begin
        acc_out <= base + prod_ext;
      end else if (shift_en) begin
        acc_out <= acc_in;
      end
    end
  end
endmodule

// File: rtl/osmm_array.sv
module osmm_array #(
  parameter int N  = osmm_pkg::DIM_DEF,
  parameter int DW = osmm_pkg::OPW_DEF,
  parameter int AW = osmm_pkg::ACCW_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [N*N*DW-1:0]    a_mat,
  input  logic [N*N*DW-1:0]    b_mat,
  output logic signed [AW-1:0] out_data,
  output logic                 out_valid,
  output logic                 done
);
  localparam int CNT_MAX = (3 * N - 2 > N * N) ? 3 * N - 2 : N * N;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int CELLS   = N * N;

  logic          busy;
  logic          capture;
  logic          comp_en;
  logic          clr_acc;
  logic          shift_en;
  logic [CW-1:0] step;

  logic [N*DW-1:0]         a_edge;
  logic [N*DW-1:0]         b_edge;
  logic [N*(N+1)*DW-1:0]   a_bus;
  logic [(N+1)*N*DW-1:0]   b_bus;
  logic [CELLS*AW-1:0]     acc_bus;
  logic [CELLS*AW-1:0]     acc_next;

  mm_sequencer #(.N(N), .CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .capture  (capture),
    .comp_en  (comp_en),
    .clr_acc  (clr_acc),
    .shift_en (shift_en),
    .step     (step),
    .valid_q  (out_valid),
    .done_q   (done)
  );

  mm_edge_feeder #(.N(N), .DW(DW), .CW(CW)) u_feed (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .comp_en (comp_en),
    .step    (step),
    .a_mat   (a_mat),
    .b_mat   (b_mat),
    .a_edge  (a_edge),
    .b_edge  (b_edge)
  );

  // Drain chain: each cell takes the accumulator of its row-major successor.
  assign acc_next = {AW'(0), acc_bus[CELLS*AW-1:AW]};

  for (genvar e = 0; e < N; e++) begin : g_edge
    assign a_bus[(e*(N+1))*DW +: DW] = a_edge[e*DW +: DW];
    assign b_bus[e*DW +: DW]         = b_edge[e*DW +: DW];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int K = i * N + j;
      mm_mac_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .comp_en  (comp_en),
        .clr_acc  (clr_acc),
        .shift_en (shift_en),
        .a_in     (a_bus[(i*(N+1)+j)*DW +: DW]),
        .b_in     (b_bus[(i*N+j)*DW +: DW]),
        .acc_in   (acc_next[K*AW +: AW]),
        .a_out    (a_bus[(i*(N+1)+j+1)*DW +: DW]),
        .b_out    (b_bus[((i+1)*N+j)*DW +: DW]),
        .acc_out  (acc_bus[K*AW +: AW])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else if (shift_en) begin
      out_data <= acc_bus[AW-1:0];
    end
  end
endmodule

// File: rtl/osmm_array_chk.sv
module osmm_array_chk #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic                      busy,
  input logic                      out_valid,
  input logic                      done,
  input logic [N*(N+1)*DW-1:0]     a_bus,
  input logic [(N+1)*N*DW-1:0]     b_bus
);
  localparam int LAT  = 3 * N - 1;
  localparam int LIM  = 3 * N + N * N + 4;
  localparam int TW   = $clog2(LIM + 1);

  logic [TW-1:0] since_go;
  logic [TW-1:0] vrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_go <= TW'(LIM);
      vrun     <= '0;
    end else begin
      if (start && !busy)          since_go <= '0;
      else if (since_go != TW'(LIM)) since_go <= since_go + 1'b1;
      vrun <= out_valid ? vrun + 1'b1 : '0;
    end
  end

  a_r4_first_result: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> since_go == TW'(LAT));

  a_r3_drain_len: assert property (@(posedge clk) disable iff (rst)
    done |-> vrun == TW'(N * N));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid && $past(out_valid));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !out_valid) |=> busy);

  // R2: operands move one cell per cycle without modification.
  for (genvar i = 0; i < N; i++) begin : g_hop_r
    for (genvar j = 0; j < N; j++) begin : g_hop_c
      a_r2_a_hop: assert property (@(posedge clk) disable iff (rst)
        a_bus[(i*(N+1)+j+1)*DW +: DW] == $past(a_bus[(i*(N+1)+j)*DW +: DW]));
      a_r2_b_hop: assert property (@(posedge clk) disable iff (rst)
        b_bus[((i+1)*N+j)*DW +: DW] == $past(b_bus[(i*N+j)*DW +: DW]));
    end
  end
endmodule

bind osmm_array osmm_array_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .out_valid (out_valid),
  .done      (done),
  .a_bus     (a_bus),
  .b_bus     (b_bus)
);

// File: tb/tb_osmm_array.sv
`timescale 1ns/1ps
module tb_osmm_array;
  localparam int N    = 3;
  localparam int DW   = 8;
  localparam int AW   = 20;
  localparam int MW   = N * N * DW;
  localparam int VFST = 3 * N - 1;
  localparam int VLST = 3 * N - 2 + N * N;
  localparam int DCYC = VLST + 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [MW-1:0]        a_mat = '0;
  logic [MW-1:0]        b_mat = '0;
  logic signed [AW-1:0] out_data;
  logic                 out_valid;
  logic                 done;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  osmm_array #(.N(N), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .out_data(out_data), .out_valid(out_valid), .done(done)
  );

  function automatic int elem(input logic [MW-1:0] m, input int i, input int j);
    logic signed [DW-1:0] v;
    v = m[(i*N+j)*DW +: DW];
    return int'(v);
  endfunction

  function automatic int prod_ref(input logic [MW-1:0] a, input logic [MW-1:0] b, input int idx);
    int s = 0;
    for (int k = 0; k < N; k++) s += elem(a, idx / N, k) * elem(b, k, idx % N);
    return s;
  endfunction

  function automatic logic [MW-1:0] rand_mat();
    logic [MW-1:0] m;
    for (int e = 0; e < N * N; e++) m[e*DW +: DW] = DW'($urandom);
    return m;
  endfunction

  function automatic logic [MW-1:0] fill_mat(input logic [DW-1:0] v);
    logic [MW-1:0] m;
    for (int e = 0; e < N * N; e++) m[e*DW +: DW] = v;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // mode 0: plain, 1: extra start mid-run (R6), 2: operands scrambled after capture (R8).
  // Returns at the negedge of the done cycle with start low.
  task automatic run(input logic [MW-1:0] a, input logic [MW-1:0] b, input string tag, input int mode);
    int exp;
    a_mat = a;
    b_mat = b;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (mode == 2) begin
      a_mat = rand_mat();
      b_mat = rand_mat();
    end
    for (int c = 1; c <= DCYC; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (mode == 1 && c == 5) begin
        a_mat = rand_mat();
        b_mat = rand_mat();
        start = 1'b1;
      end
      if (mode == 1 && c == 6) start = 1'b0;
      if (c >= VFST && c <= VLST) begin
        exp = prod_ref(a, b, c - VFST);
        check(out_valid === 1'b1, {tag, " R4 valid"}, int'(out_valid), 1);
        check(out_data == AW'(exp), {tag, " R2 R3 data"}, int'(out_data), exp);
      end else begin
        check(out_valid === 1'b0, {tag, " R4 valid idle"}, int'(out_valid), 0);
      end
      check(done === (c == DCYC), {tag, " R5 done"}, int'(done), int'(c == DCYC));
    end
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0 && done === 1'b0, req, int'(out_valid) + 2 * int'(done), 0);
    end
  endtask

  initial begin
    logic [MW-1:0] ident;
    logic [MW-1:0] ra;
    logic [MW-1:0] rb;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(out_data == '0, "R1 data", int'(out_data), 0);

    ident = '0;
    for (int d = 0; d < N; d++) ident[(d*N+d)*DW +: DW] = DW'(1);
    rb = rand_mat();
    run(ident, rb, "R2 identity", 0);
    expect_quiet(2, "R5 quiet");

    for (int t = 0; t < 6; t++) begin
      ra = rand_mat();
      rb = rand_mat();
      run(ra, rb, "R3 random", 0);
      @(negedge clk);
    end

    run(fill_mat(8'h80), fill_mat(8'h80), "R9 min", 0);
    @(negedge clk);
    run(fill_mat(8'h80), fill_mat(8'h7F), "R9 mixed", 0);
    @(negedge clk);

    ra = rand_mat();
    rb = rand_mat();
    run(ra, rb, "R6 busy start", 1);
    expect_quiet(DCYC + 2, "R6 no extra run");

    ra = rand_mat();
    rb = rand_mat();
    run(ra, rb, "R8 late change", 2);
    a_mat = '0;
    b_mat = '0;

    // R10 / R7: restart in done cycle, then zero operands right after a full run.
    ra = rand_mat();
    rb = rand_mat();
    run(ra, rb, "R10 first", 0);
    run(fill_mat(8'h00), rand_mat(), "R7 R10 zero", 0);
    run(fill_mat(8'h7F), fill_mat(8'h7F), "R7 R10 max", 0);
    run(ident, ident, "R7 identity", 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R4 watchdog expired got=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule